// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

An 8-bit up-counter, advanced by a prescaled copy of the peripheral clock, whose overflow handling is chosen by a mode bit. In watchdog mode, software must keep writing zero to the counter. If it does not, the counter wraps from 0xFF to 0x00, a watchdog flag is set and a reset request pulse is driven. The pulse is either a power-on type or a manual type, and the two types have different lengths. In interval mode, each wrap sets an interval flag and raises an interrupt, which gives a periodic tick. In both modes the counter keeps counting after the event.

Software drives the block through a small register port. Select 0 is the control/status byte and select 1 is the counter. The reset controller and the interrupt controller that receive the requests are outside this block.

Top module: `wdog_itimer`

## Requirements
- R1: After reset, the control byte and the counter both read 0x00, and rst_req, stat_hi, rst_kind and irq are all low.
- R2: wr_sel/rd_sel 0 addresses the control byte and 1 addresses the counter. The control byte bits are: [7] enable, [6] mode (1 watchdog, 0 interval), [5] reset type (1 manual, 0 power-on), [4] watchdog flag, [3] interval flag, [2:0] clock select. Reads are combinational.
- R3: Clock select codes 0..7 advance the counter once every 1, 4, 16, 32, 64, 256, 1024 or 4096 clock cycles. When the counter is loaded with V and the enable is then written, the first overflow takes effect (256-V)*ratio clock edges after the enabling write.
- R4: A counter write is visible on the next cycle and overrides any increment in that cycle. Writing zero to it periodically prevents overflow in watchdog mode.
- R5: In interval mode an overflow sets the interval flag and no reset is requested. irq is high while the interval flag is set.
- R6: In watchdog mode an overflow sets the watchdog flag and starts a reset request. While the request is active, both stat_hi bits are high and rst_kind shows the selected type (1 manual). irq stays low.
- R7: A power-on reset request lasts exactly one count-clock period, which is ratio clock cycles.
- R8: A manual reset request lasts exactly 5 clock cycles.
- R9: After an overflow the counter wraps to 0x00 and continues counting.
- R10: The flags hold until software writes 0 to them. Writing 1 to a flag bit neither sets it nor clears it. irq falls on the cycle after the flag is cleared.
- R11: While enable is 0 the counter holds its value and no reset or interrupt is raised. Clearing enable also clears the prescaler, so the next run starts from a full count-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 counter |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 control, 1 counter |
| rd_data | output | 8 | Read data |
| rst_req | output | 1 | Reset request pulse |
| rst_kind | output | 1 | Type of the last reset request: 1 manual, 0 power-on |
| stat_hi | output | 2 | Status outputs, both high during a reset request |
| irq | output | 1 | Interval timer interrupt request |

## Verification
Register writes take effect at the clock edge that samples them. An overflow therefore lands exactly (256-V)*ratio edges after the enabling write, and the flag, irq and rst_req all change at that same edge. The bench counts posedges from the edge of the enabling write and samples every output at the following negedge, so each count it compares is an exact edge number. A reset pulse is measured as the number of consecutive negedge samples at which it is high: ratio samples for a power-on request and five for a manual request.

// File: rtl/wdog_itimer.sv
`timescale 1ns/1ps
module wdog_itimer #(
  parameter int MANUAL_CYCLES = 5,
  parameter int DIV_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  output logic       rst_req,
  output logic       rst_kind,
  output logic [1:0] stat_hi,
  output logic       irq
);
  localparam int PW = DIV_W + 1;

  logic             en_q, wdm_q, man_q, wflg_q, iflg_q, kind_q;
  logic [2:0]       cks_q;
  logic [7:0]       cnt_q;
  logic [DIV_W-1:0] div_q, lim;
  logic [PW-1:0]    pls_q;
  logic             wr_c, wr_n, tick, ovf;

  always_comb begin
    case (cks_q)
      3'd0: lim = DIV_W'(0);
      3'd1: lim = DIV_W'(3);
      3'd2: lim = DIV_W'(15);
      3'd3: lim = DIV_W'(31);
      3'd4: lim = DIV_W'(63);
      3'd5: lim = DIV_W'(255);
      3'd6: lim = DIV_W'(1023);
      default: lim = DIV_W'(4095);
    endcase
  end

  assign wr_c = wr_en && !wr_sel;
  assign wr_n = wr_en && wr_sel;
  assign tick = en_q && (div_q >= lim);
  assign ovf  = tick && (cnt_q == 8'hFF) && !wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; wdm_q <= 1'b0; man_q <= 1'b0; cks_q <= '0;
      wflg_q <= 1'b0; iflg_q <= 1'b0; kind_q <= 1'b0;
      cnt_q <= '0; div_q <= '0; pls_q <= '0;
    end else begin
      if (wr_c) {en_q, wdm_q, man_q, cks_q} <= {wr_data[7:5], wr_data[2:0]};
      wflg_q <= (wflg_q & ~(wr_c & ~wr_data[4])) | (ovf & wdm_q);
      iflg_q <= (iflg_q & ~(wr_c & ~wr_data[3])) | (ovf & ~wdm_q);
      div_q  <= (!en_q || tick) ? '0 : div_q + 1'b1;
      if (wr_n)      cnt_q <= wr_data;
      else if (tick) cnt_q <= cnt_q + 8'd1;
      if (ovf && wdm_q) begin
        pls_q  <= man_q ? PW'(MANUAL_CYCLES) : {1'b0, lim} + PW'(1);
        kind_q <= man_q;
      end else if (pls_q != '0) begin
        pls_q <= pls_q - PW'(1);
      end
    end
  end

  assign rd_data  = rd_sel ? cnt_q : {en_q, wdm_q, man_q, wflg_q, iflg_q, cks_q};
  assign rst_req  = (pls_q != '0);
  assign rst_kind = kind_q;
  assign stat_hi  = {2{rst_req}};
  assign irq      = iflg_q;
endmodule

// File: rtl/wdog_itimer_chk.sv
`timescale 1ns/1ps
module wdog_itimer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] cnt_q,
  input logic       en_q,
  input logic       wdm_q,
  input logic       rst_req,
  input logic       rst_kind,
  input logic [1:0] stat_hi,
  input logic       irq
);
  logic [12:0] hi_len;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hi_len <= '0;
    else        hi_len <= rst_req ? hi_len + 13'd1 : '0;

  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_sel) |=> cnt_q == $past(wr_data)); // R4
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> ($past(cnt_q) == 8'hFF && !$past(wdm_q))); // R5
  AST_RST_WDOG_ONLY: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_req) |-> ($past(wdm_q) && $past(en_q))); // R6
  AST_STAT_PAIR: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> stat_hi == 2'b11); // R6
  AST_MANUAL_LEN: assert property (@(posedge clk) disable iff (!rst_n) ($fell(rst_req) && rst_kind) |-> hi_len == 13'd5); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!en_q && !(wr_en && wr_sel)) |=> $stable(cnt_q)); // R11
endmodule

bind wdog_itimer wdog_itimer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cnt_q(cnt_q), .en_q(en_q), .wdm_q(wdm_q), .rst_req(rst_req),
  .rst_kind(rst_kind), .stat_hi(stat_hi), .irq(irq)
);

// File: tb/wdog_itimer_tb_top.sv
`timescale 1ns/1ps
module wdog_itimer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic rst_req, rst_kind, irq;
  logic [1:0] stat_hi;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdog_itimer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .rst_req(rst_req),
    .rst_kind(rst_kind), .stat_hi(stat_hi), .irq(irq));

  // {clock select, initial count, edges to first overflow}
  localparam logic [26:0] VEC [0:7] = '{
    {3'd0, 8'hF0, 16'd16},  {3'd1, 8'hFC, 16'd16},
    {3'd2, 8'hFE, 16'd32},  {3'd3, 8'hFF, 16'd32},
    {3'd4, 8'hFE, 16'd128}, {3'd5, 8'hFF, 16'd256},
    {3'd6, 8'hFF, 16'd1024},{3'd7, 8'hFF, 16'd4096}};

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic sel, output logic [7:0] d);
    rd_sel = sel; #1 d = rd_data;
  endtask

  task automatic edges_until(ref logic sig, output int n);
    n = 0;
    while (!sig && n < 6000) begin @(posedge clk); n++; @(negedge clk); end
  endtask

  task automatic pulse_len(output int len);
    len = 0;
    while (rst_req && len < 6000) begin len++; @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rd(0, v); check("R1 ctrl", v, 0);
    rd(1, v); check("R1 count", v, 0);
    check("R1 outputs", {rst_req, rst_kind, stat_hi, irq}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      wr(0, 8'h00); wr(1, VEC[i][23:16]); wr(0, {5'b10000, VEC[i][26:24]});
      edges_until(irq, n);
      check($sformatf("R3 cks%0d edges", i), n, int'(VEC[i][15:0]));
      rd(0, v); check("R5 iflag", v[3], 1);
      check("R5 no reset", rst_req, 0);
    end

    wr(0, 8'h00); wr(1, 8'hFF); wr(0, 8'h80);
    repeat (6) @(posedge clk); @(negedge clk);
    rd(1, v); check("R9 resumed count", v, 5);
    check("R5 irq", irq, 1);
    wr(0, 8'h88); check("R10 write1 keeps irq", irq, 1);
    wr(0, 8'h80); check("R10 clear drops irq", irq, 0);
    rd(0, v); check("R10 iflag cleared", v[3], 0);

    wr(0, 8'h7D); rd(0, v); check("R2 R10 ctrl readback", v, 8'h65);
    wr(1, 8'hFF); repeat (300) @(posedge clk); @(negedge clk);
    rd(1, v); check("R11 hold count", v, 8'hFF);
    check("R11 no events", {rst_req, irq}, 0);

    wr(0, 8'h00); wr(1, 8'h00); wr(0, 8'h82);
    repeat (10) @(posedge clk);
    wr(0, 8'h02); wr(1, 8'hFF); wr(0, 8'h82);
    edges_until(irq, n); check("R11 prescaler restart", n, 16);

    wr(0, 8'h00); wr(1, 8'hFF); wr(0, 8'hC2);
    edges_until(rst_req, n); check("R6 wdog edges", n, 16);
    check("R6 status", stat_hi, 3);
    check("R6 kind power-on", rst_kind, 0);
    check("R6 no irq", irq, 0);
    rd(0, v); check("R6 wflag", v, 8'hD2);
    pulse_len(n); check("R7 power-on length", n, 16);

    wr(0, 8'h00); wr(1, 8'hFF); wr(0, 8'hE5);
    edges_until(rst_req, n); check("R8 manual edges", n, 256);
    check("R6 kind manual", rst_kind, 1);
    pulse_len(n); check("R8 manual length", n, 5);

    wr(0, 8'h00); wr(1, 8'hF0); wr(0, 8'hC0);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      for (int j = 0; j < 8; j++) begin @(posedge clk); @(negedge clk); n += int'(rst_req); end
      wr(1, 8'h00);
    end
    check("R4 kicks prevent reset", n, 0);
    rd(0, v); check("R4 wflag clear", v[4], 0);
    wr(0, 8'h00); wr(1, 8'h5A); rd(1, v); check("R4 R2 count load", v, 8'h5A);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule